// File: doc/BRIEF.md
# Line Pixel Uniformity Statistics Unit

This block watches one digitized scan line go by as a stream of samples. Each sample carries a flag that says whether it comes from a light-sensitive pixel that counts, or from a shielded or unused position that does not. Over the counted pixels it keeps a running sum, a minimum and a maximum in a single pass. At the end-of-line marker it runs a shift-and-subtract divider, first to form the line mean and then, in illuminated mode, to express the worst deviation from that mean as a percentage of the mean.

In dark mode, the same mean is read as the average dark level and the same peak deviation as the dark non-uniformity. The percentage is skipped in that mode. All results are published together with a one-cycle done strobe and are held until the next line completes. The line length is a parameter, and the mean always divides by that nominal count. A line that delivers a different number of counted pixels is flagged.

Top module: `line_uniformity_stats`

## Requirements
- R1: A beat with `i_sol` high discards all accumulated state and starts a new line that includes that beat's own sample. Samples from an unfinished earlier line have no effect on the next result.
- R2: Only beats with `i_pix_ok` high contribute to the sum, minimum and maximum. Other samples, whatever their value, change no result.
- R3: `o_mean` equals floor(sum of counted samples / NPIX).
- R4: `o_peak_dev` equals the larger of (max − mean) and (mean − min), using the reported mean. A term whose difference would be negative counts as 0.
- R5: In illuminated mode with a nonzero mean, `o_pct` equals floor(peak_dev × 25600 / mean). This is the percentage with 8 fractional bits, so 1.0 % reads as 256.
- R6: In illuminated mode with a mean of 0, `o_pct` is all ones and `o_zero_err` is 1. Otherwise `o_zero_err` is 0.
- R7: `o_cnt_err` is 1 when the line held a number of flagged pixels other than NPIX. Flagged pixels after the NPIX-th are left out of sum, minimum and maximum.
- R8: When `i_dark` is high on the end-of-line beat, the result is a dark result. `o_mean` is the average dark level, `o_peak_dev` is the dark non-uniformity, and `o_pct` and `o_zero_err` are 0.
- R9: `o_done` is high for exactly one cycle per finished line. All result outputs change only in that cycle and hold their values until the next done.
- R10: After reset, `o_done`, all results and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| i_valid | input | 1 | A sample beat is present |
| i_sol | input | 1 | Beat is the first of a line |
| i_eol | input | 1 | Beat is the last of a line |
| i_pix_ok | input | 1 | Beat belongs to a counted pixel |
| i_data | input | DW | Sample value |
| i_dark | input | 1 | Dark-frame mode, taken on the end-of-line beat |
| o_done | output | 1 | One-cycle result strobe |
| o_mean | output | DW | Line mean or average dark level |
| o_peak_dev | output | DW | Largest deviation from the mean |
| o_pct | output | DW+15 | Non-uniformity percentage, 8 fractional bits |
| o_zero_err | output | 1 | Mean was zero in illuminated mode |
| o_cnt_err | output | 1 | Counted-pixel total differed from NPIX |

## Verification
Some properties are checked by assertions on every cycle. The done strobe never lasts two cycles. A complete line's mean lies between its extremes, and the peak deviation never exceeds the spread. A dark result or a zero-mean result carries its fixed percentage code. The exact arithmetic cannot be seen by a cycle-local property and is shown only by the bench scenarios. These cover floor division of the mean, selection of the larger deviation side, the percentage value, exclusion of unflagged and surplus pixels, and the discarding of an abandoned line when a new line starts.

// File: rtl/line_uniformity_stats.sv
module line_uniformity_stats #(
  parameter int DW   = 12,
  parameter int NPIX = 10680
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            i_valid,
  input  logic            i_sol,
  input  logic            i_eol,
  input  logic            i_pix_ok,
  input  logic [DW-1:0]   i_data,
  input  logic            i_dark,
  output logic            o_done,
  output logic [DW-1:0]   o_mean,
  output logic [DW-1:0]   o_peak_dev,
  output logic [DW+14:0]  o_pct,
  output logic            o_zero_err,
  output logic            o_cnt_err
);
  localparam int CW  = $clog2(NPIX + 2);
  localparam int SW  = DW + $clog2(NPIX + 1);
  localparam int PW  = DW + 15;
  localparam int NW  = (SW > PW) ? SW : PW;
  localparam int DVW = (DW > CW) ? DW : CW;
  localparam int IW  = $clog2(NW + 1);

  typedef enum logic [1:0] {ST_ACC, ST_DIVM, ST_DEV, ST_DIVP} st_t;
  st_t st;

  logic [CW-1:0]  cnt;
  logic [SW-1:0]  sum;
  logic [DW-1:0]  mn, mx;
  logic           dark_q;
  logic [DVW-1:0] rem, dvs;
  logic [NW-1:0]  quo;
  logic [IW-1:0]  it;
  logic [DW-1:0]  mean_t, dev_t;

  // next accumulator values for the current beat
  logic [CW-1:0] b_cnt, n_cnt;
  logic [SW-1:0] b_sum, n_sum;
  logic [DW-1:0] b_mn, b_mx, n_mn, n_mx;
  logic          take;

  assign b_cnt = i_sol ? '0 : cnt;
  assign b_sum = i_sol ? '0 : sum;
  assign b_mn  = i_sol ? '1 : mn;
  assign b_mx  = i_sol ? '0 : mx;
  assign take  = i_pix_ok && (b_cnt < CW'(NPIX));
  assign n_sum = take ? b_sum + SW'(i_data) : b_sum;
  assign n_mn  = (take && i_data < b_mn) ? i_data : b_mn;
  assign n_mx  = (take && i_data > b_mx) ? i_data : b_mx;
  assign n_cnt = (i_pix_ok && b_cnt <= CW'(NPIX)) ? b_cnt + 1'b1 : b_cnt;

  // one restoring-division step
  logic [DVW:0]   r_sh;
  logic           r_ge;
  logic [DVW-1:0] r_nx;
  logic [NW-1:0]  q_nx;

  assign r_sh = {rem, quo[NW-1]};
  assign r_ge = r_sh >= {1'b0, dvs};
  assign r_nx = r_ge ? DVW'(r_sh - {1'b0, dvs}) : DVW'(r_sh);
  assign q_nx = {quo[NW-2:0], r_ge};

  // deviation from the freshly divided mean
  logic [DW-1:0] q_mean, d_hi, d_lo, dev_c;
  assign q_mean = quo[DW-1:0];
  assign d_hi   = (mx >= q_mean) ? mx - q_mean : '0;
  assign d_lo   = (q_mean >= mn) ? q_mean - mn : '0;
  assign dev_c  = (d_hi > d_lo) ? d_hi : d_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_ACC;
      cnt <= '0; sum <= '0; mn <= '1; mx <= '0;
      dark_q <= 1'b0;
      rem <= '0; dvs <= '0; quo <= '0; it <= '0;
      mean_t <= '0; dev_t <= '0;
      o_done <= 1'b0; o_mean <= '0; o_peak_dev <= '0; o_pct <= '0;
      o_zero_err <= 1'b0; o_cnt_err <= 1'b0;
    end else begin
      o_done <= 1'b0;
      case (st)
        ST_ACC: if (i_valid) begin
          cnt <= n_cnt; sum <= n_sum; mn <= n_mn; mx <= n_mx;
          if (i_eol) begin
            dark_q <= i_dark;
            rem <= '0;
            quo <= NW'(n_sum);
            dvs <= DVW'(NPIX);
            it  <= '0;
            st  <= ST_DIVM;
          end
        end
        ST_DIVM: begin
          rem <= r_nx; quo <= q_nx; it <= it + 1'b1;
          if (it == IW'(NW - 1)) st <= ST_DEV;
        end
        ST_DEV: begin
          mean_t <= q_mean;
          dev_t  <= dev_c;
          if (dark_q || q_mean == '0) begin
            o_done     <= 1'b1;
            o_mean     <= q_mean;
            o_peak_dev <= dev_c;
            o_pct      <= dark_q ? '0 : '1;
            o_zero_err <= !dark_q;
            o_cnt_err  <= cnt != CW'(NPIX);
            st <= ST_ACC;
          end else begin
            rem <= '0;
            quo <= NW'(dev_c) * NW'(25600);
            dvs <= DVW'(q_mean);
            it  <= '0;
            st  <= ST_DIVP;
          end
        end
        default: begin
          rem <= r_nx; quo <= q_nx; it <= it + 1'b1;
          if (it == IW'(NW - 1)) begin
            o_done     <= 1'b1;
            o_mean     <= mean_t;
            o_peak_dev <= dev_t;
            o_pct      <= q_nx[PW-1:0];
            o_zero_err <= 1'b0;
            o_cnt_err  <= cnt != CW'(NPIX);
            st <= ST_ACC;
          end
        end
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    o_done |=> !o_done); // R9
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !o_done |-> $stable(o_mean) && $stable(o_pct)); // R9
  AST_MEAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (o_done && !o_cnt_err) |-> (o_mean >= mn && o_mean <= mx)); // R3
  AST_DEV_LE_SPREAD: assert property (@(posedge clk) disable iff (!rst_n)
    (o_done && !o_cnt_err) |-> (o_peak_dev <= mx - mn)); // R4
  AST_ZERO_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (o_done && o_zero_err) |-> (&o_pct)); // R6
  AST_DARK_NO_PCT: assert property (@(posedge clk) disable iff (!rst_n)
    (o_done && dark_q) |-> (o_pct == '0 && !o_zero_err)); // R8
endmodule

// File: tb/line_uniformity_stats_tb.sv
module line_uniformity_stats_tb;
  localparam int DW = 12;
  localparam int NPIX = 8;
  localparam int PW = DW + 15;

  logic clk = 0, rst_n = 0;
  logic i_valid = 0, i_sol = 0, i_eol = 0, i_pix_ok = 0, i_dark = 0;
  logic [DW-1:0] i_data = '0;
  logic o_done, o_zero_err, o_cnt_err;
  logic [DW-1:0] o_mean, o_peak_dev;
  logic [PW-1:0] o_pct;

  int checks = 0, errors = 0;
  int px_v [0:31];
  bit px_k [0:31];

  line_uniformity_stats #(.DW(DW), .NPIX(NPIX)) u_dut (
    .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_sol(i_sol), .i_eol(i_eol),
    .i_pix_ok(i_pix_ok), .i_data(i_data), .i_dark(i_dark), .o_done(o_done),
    .o_mean(o_mean), .o_peak_dev(o_peak_dev), .o_pct(o_pct),
    .o_zero_err(o_zero_err), .o_cnt_err(o_cnt_err));

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int n, input bit sol_first, input bit with_eol, input bit dark);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      i_valid = 1; i_sol = sol_first && (i == 0); i_eol = with_eol && (i == n - 1);
      i_pix_ok = px_k[i]; i_data = DW'(px_v[i]); i_dark = dark;
    end
    @(negedge clk);
    i_valid = 0; i_sol = 0; i_eol = 0; i_pix_ok = 0; i_dark = 0;
  endtask

  task automatic run_line(input string req, input int n, input bit dark);
    longint sum = 0, mn = 4095, mx = 0, mean, dhi, dlo, dev, pct;
    int cnt = 0, t = 0;
    for (int i = 0; i < n; i++)
      if (px_k[i]) begin
        if (cnt < NPIX) begin
          sum += px_v[i];
          if (px_v[i] < mn) mn = px_v[i];
          if (px_v[i] > mx) mx = px_v[i];
        end
        cnt++;
      end
    mean = sum / NPIX;
    dhi = (mx >= mean) ? mx - mean : 0;
    dlo = (mean >= mn) ? mean - mn : 0;
    dev = (dhi > dlo) ? dhi : dlo;
    if (dark) pct = 0;
    else if (mean == 0) pct = (longint'(1) << PW) - 1;
    else pct = dev * 25600 / mean;
    drive(n, 1, 1, dark);
    while (o_done !== 1'b1 && t < 500) begin
      @(posedge clk); #1; t++;
    end
    chk({req, " done seen"}, o_done, 1);
    chk({req, " mean R3"}, o_mean, mean);
    chk({req, " peak dev R4"}, o_peak_dev, dev);
    chk({req, " pct R5"}, o_pct, pct);
    chk({req, " zero err R6"}, o_zero_err, (!dark && mean == 0) ? 1 : 0);
    chk({req, " count err R7"}, o_cnt_err, (cnt != NPIX) ? 1 : 0);
    @(posedge clk); #1;
    chk({req, " single done R9"}, o_done, 0);
    chk({req, " held mean R9"}, o_mean, mean);
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < 32; i++) begin px_v[i] = 0; px_k[i] = 0; end
    for (int i = 0; i < n; i++) px_k[i] = 1;
  endtask

  task automatic t_reset;
    chk("R10 done", o_done, 0);
    chk("R10 mean", o_mean, 0);
    chk("R10 pct", o_pct, 0);
    chk("R10 flags", {o_zero_err, o_cnt_err}, 0);
  endtask

  task automatic t_flat_with_masked;
    fill(14);
    for (int i = 0; i < 14; i++) px_v[i] = 100;
    for (int i = 0; i < 3; i++) begin px_k[i] = 0; px_v[i] = 4095; end
    for (int i = 11; i < 14; i++) begin px_k[i] = 0; px_v[i] = 0; end
    run_line("R2 flat masked", 14, 0);
  endtask

  task automatic t_ramp;
    fill(8);
    for (int i = 0; i < 8; i++) px_v[i] = 1000 + 37 * i;
    run_line("R5 ramp", 8, 0);
  endtask

  task automatic t_low_side;
    fill(8);
    for (int i = 0; i < 8; i++) px_v[i] = 2000;
    px_v[4] = 300;
    run_line("R4 low side", 8, 0);
  endtask

  task automatic t_zero;
    fill(8);
    run_line("R6 zero mean", 8, 0);
  endtask

  task automatic t_dark;
    fill(8);
    for (int i = 0; i < 8; i++) px_v[i] = 20 + (i % 3);
    px_v[6] = 31;
    run_line("R8 dark", 8, 1);
  endtask

  task automatic t_short_long;
    fill(6);
    for (int i = 0; i < 6; i++) px_v[i] = 500;
    run_line("R7 short", 6, 0);
    fill(11);
    for (int i = 0; i < 8; i++) px_v[i] = 800 + i;
    for (int i = 8; i < 11; i++) px_v[i] = 4095;
    run_line("R7 long", 11, 0);
  endtask

  task automatic t_restart;
    fill(5);
    for (int i = 0; i < 5; i++) px_v[i] = 4000;
    drive(5, 1, 0, 0);
    fill(8);
    for (int i = 0; i < 8; i++) px_v[i] = 50 + 10 * i;
    run_line("R1 restart", 8, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_flat_with_masked;
    t_ramp;
    t_low_side;
    t_zero;
    t_dark;
    t_short_long;
    t_restart;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule